// File: doc/BRIEF.md
# Noise-Shaped Phase Synthesizer Core

This block is the digital core of a direct frequency synthesizer. A 16-bit phase register advances by a programmable tuning word on every enabled clock and wraps modulo 2^16. The low phase bits are not simply dropped. The phase passes through a fourth-order error-feedback delta-sigma requantizer that works on phase values and reduces it to 8 bits. The truncation error is pushed towards high frequencies, so a 256-entry sine table gives the spectral quality that would otherwise need a table sixteen times larger.

Each enabled clock produces one sample: a 12-bit two's-complement amplitude and the 8-bit shaped phase that addressed the table, marked by a valid strobe. The requantizer's feedback is split across two registers. The loop that must close in one cycle is therefore a single two-operand addition, and the core keeps up with the full sample rate. Digital-to-analog conversion and reconstruction filtering lie outside the block.

Top module: `phase_shaped_nco`

## Requirements
- R1: After reset the first emitted sample has phase 0, and the internal phase advances by `tune_word` modulo 2^16 on every clock where `en` is 1.
- R2: For sample n with accumulator phase x(n), the block forms u(n) = (x(n) + 4e(n-1) - 6e(n-2) + 4e(n-3) - e(n-4)) mod 2^16. Here e(k) is the low byte of u(k), and e(k) = 0 for samples before the first one after reset. The emitted phase is the upper byte of u(n).
- R3: For every sample, 256 times the emitted phase minus x(n), taken modulo 2^16 as a signed value, lies in [-2040, 2040].
- R4: When `tune_word` is a multiple of 256, the emitted phase equals the upper byte of x(n) exactly.
- R5: The running sum, since reset, of the signed deviations defined in R3 stays within [-1020, 1020], so the mean emitted phase tracks the accumulator.
- R6: `amp_out` is round(2047 * sin(2*pi*p/256)) within one LSB, where p is the emitted phase in `phase_out`. It is exactly 0, 2047, 0 and -2047 for p = 0, 64, 128 and 192.
- R7: A sample taken on an enabled clock edge appears on `amp_out`/`phase_out` with `amp_valid` = 1 after the second following edge. Each enabled edge yields exactly one valid cycle, and samples come out in order.
- R8: While `en` is 0, the phase and requantizer state do not change, and `amp_out`/`phase_out` hold their values during cycles where `amp_valid` is 0.
- R9: Asynchronous active-low reset clears the phase, all requantizer error state and the outputs, and drops `amp_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance phase and produce a sample this cycle |
| tune_word | input | 16 | Phase increment per sample (frequency tuning word) |
| amp_out | output | 12 | Signed sine amplitude of the current sample |
| phase_out | output | 8 | Shaped phase that addressed the table for this sample |
| amp_valid | output | 1 | High for one cycle per emitted sample |

## Verification
The core is driven with a zero tuning word, a word that is a multiple of 256 and so yields exact truncation, several fine-grained words both positive and negative in the signed sense, and a gapped enable pattern. The zero and multiple-of-256 words separate the accumulator path from the error feedback: the feedback must stay silent there, and every table quarter point is visited. The fine-grained words exercise all four feedback taps and the modulo wrap, and they are compared sample by sample with an arithmetic model, with the deviation bound and the bounded running mean. The gapped enable and a reset in mid-stream show whether state freezes and clears correctly.

// File: rtl/phase_shaped_nco.sv
module phase_shaped_nco #(
  parameter int ACC_W = 16,
  parameter int PH_W  = 8,
  parameter int AMP_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [ACC_W-1:0]        tune_word,
  output logic signed [AMP_W-1:0] amp_out,
  output logic [PH_W-1:0]         phase_out,
  output logic                    amp_valid
);
  localparam int LSB_W = ACC_W - PH_W;
  localparam int DEPTH = 2 ** PH_W;
  localparam int QTR   = DEPTH / 4;
  localparam longint PEAK = (64'sd1 <<< (AMP_W - 1)) - 1;
  localparam longint HALF_PI_Q30 = 64'sd1686629713;

  function automatic logic signed [AMP_W-1:0] sin_entry(input int k);
    int kk, m;
    longint x, x2, term, sum, a;
    kk   = k % (2 * QTR);
    m    = (kk > QTR) ? (2 * QTR - kk) : kk;
    x    = longint'(m) * HALF_PI_Q30 / longint'(QTR);
    x2   = (x * x) >>> 30;
    term = x;
    sum  = x;
    for (int i = 1; i <= 6; i++) begin
      term = -((term * x2) >>> 30) / longint'((2 * i) * (2 * i + 1));
      sum  = sum + term;
    end
    a = (sum * PEAK + (64'sd1 <<< 29)) >>> 30;
    if (k >= 2 * QTR) a = -a;
    return AMP_W'(a);
  endfunction

  logic signed [AMP_W-1:0] rom [DEPTH];
  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    assign rom[k] = sin_entry(k);
  end

  logic [ACC_W-1:0] acc, acc_nxt, part, u;
  logic [LSB_W-1:0] e1, e2, e3;
  logic [ACC_W-1:0] e1x, e2x, e3x;
  logic [PH_W-1:0]  phase_q;
  logic             v1;

  assign e1x     = ACC_W'(e1);
  assign e2x     = ACC_W'(e2);
  assign e3x     = ACC_W'(e3);
  assign acc_nxt = acc + tune_word;
  assign u       = part + (e1x << 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      part    <= '0;
      e1      <= '0;
      e2      <= '0;
      e3      <= '0;
      phase_q <= '0;
    end else if (en) begin
      acc     <= acc_nxt;
      part    <= acc_nxt - ((e1x << 2) + (e1x << 1)) + (e2x << 2) - e3x;
      e1      <= u[LSB_W-1:0];
      e2      <= e1;
      e3      <= e2;
      phase_q <= u[ACC_W-1:LSB_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      amp_valid <= 1'b0;
      amp_out   <= '0;
      phase_out <= '0;
    end else begin
      v1        <= en;
      amp_valid <= v1;
      if (v1) begin
        amp_out   <= rom[phase_q];
        phase_out <= phase_q;
      end
    end
  end
endmodule

module phase_shaped_nco_chk #(
  parameter int ACC_W = 16,
  parameter int PH_W  = 8,
  parameter int AMP_W = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic [ACC_W-1:0]        tune_word,
  input logic [ACC_W-1:0]        acc,
  input logic [PH_W-1:0]         phase_q,
  input logic signed [AMP_W-1:0] amp_out,
  input logic [PH_W-1:0]         phase_out,
  input logic                    amp_valid
);
  localparam int LSB_W = ACC_W - PH_W;
  localparam int DEV   = 8 * (2 ** LSB_W - 1);
  localparam int QTR   = (2 ** PH_W) / 4;
  localparam int PEAK  = 2 ** (AMP_W - 1) - 1;

  // R1
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> acc == $past(acc) + $past(tune_word));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(acc) && $stable(phase_q)));

  // R3
  deviation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> ($signed({phase_q, {LSB_W{1'b0}}} - $past(acc)) >= -DEV &&
                   $signed({phase_q, {LSB_W{1'b0}}} - $past(acc)) <= DEV));

  // R7
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    amp_valid |-> $past(en, 2));

  // R6
  quarter_amp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_valid && phase_out == PH_W'(QTR)) |-> amp_out == AMP_W'(PEAK));
endmodule

bind phase_shaped_nco phase_shaped_nco_chk #(.ACC_W(ACC_W), .PH_W(PH_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tune_word(tune_word), .acc(acc),
  .phase_q(phase_q), .amp_out(amp_out), .phase_out(phase_out), .amp_valid(amp_valid)
);

// File: tb/phase_shaped_nco_test.sv
module phase_shaped_nco_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] tw = '0;
  logic signed [11:0] amp;
  logic [7:0]  ph;
  logic        vld;

  phase_shaped_nco uut (.clk(clk), .rst_n(rst_n), .en(en), .tune_word(tw),
                        .amp_out(amp), .phase_out(ph), .amp_valid(vld));

  int checks = 0, errors = 0, cyc = 0, dev_sum = 0;
  bit done = 0, h1 = 0, h2 = 0, first = 1;
  logic [15:0] mx = '0;
  int me1 = 0, me2 = 0, me3 = 0, me4 = 0;
  logic [7:0]  q_ph[$];
  logic [15:0] q_x[$];
  logic signed [11:0] last_amp = '0;
  logic [7:0] last_ph = '0, prev_ph = '0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_amp(input int p);
    real r;
    r = 2047.0 * $sin(2.0 * 3.14159265358979 * p / 256.0);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic model_push();
    int u, e;
    u = (int'(mx) + 4 * me1 - 6 * me2 + 4 * me3 - me4) & 32'hFFFF;
    e = u & 255;
    q_ph.push_back(8'(u >> 8));
    q_x.push_back(mx);
    me4 = me3; me3 = me2; me2 = me1; me1 = e;
    mx = mx + tw;
  endtask

  task automatic drive(input bit e, input int n);
    repeat (n) begin
      @(posedge clk); #1;
      en = e;
      if (e) model_push();
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    en = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    q_ph.delete(); q_x.delete();
    mx = '0; me1 = 0; me2 = 0; me3 = 0; me4 = 0;
    dev_sum = 0; first = 1;
    @(negedge clk);
    // R9 reset state
    check(vld == 0, "R9", "valid in reset", int'(vld), 0);
    check(amp == 0, "R9", "amp in reset", int'(amp), 0);
    check(ph == 0, "R9", "phase in reset", int'(ph), 0);
    @(posedge clk); #1;
    rst_n = 1;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog R1..all: actual %0d cycles expected below 100000", cyc);
      finish_up();
    end
    if (!rst_n) begin
      h1 = 0; h2 = 0;
    end else begin
      // R7 valid exactly two edges after each enabled edge
      check(vld == h2, "R7", "valid timing", int'(vld), int'(h2));
      if (vld) begin
        if (q_ph.size() == 0) check(0, "R7", "unexpected sample", int'(ph), -1);
        else begin
          logic [7:0] eph;
          logic [15:0] ex;
          int dev, ra;
          eph = q_ph.pop_front();
          ex  = q_x.pop_front();
          // R2 exact shaped phase
          check(ph == eph, "R2", "shaped phase", int'(ph), int'(eph));
          dev = int'($signed(16'({ph, 8'h00} - ex)));
          check(dev >= -2040 && dev <= 2040, "R3", "deviation", dev, 0);
          dev_sum += dev;
          check(dev_sum >= -1020 && dev_sum <= 1020, "R5", "running deviation", dev_sum, 0);
          ra = ref_amp(int'(ph));
          if (ph[5:0] == 0)
            check(int'(amp) == ra, "R6", "quarter amplitude", int'(amp), ra);
          else
            check(int'(amp) - ra <= 1 && ra - int'(amp) <= 1, "R6", "amplitude", int'(amp), ra);
          if (tw[7:0] == 0) begin
            check(ph == ex[15:8], "R4", "exact truncation", int'(ph), int'(ex[15:8]));
            if (first) check(ph == 0, "R1", "first phase", int'(ph), 0);
            else check(ph == 8'(prev_ph + tw[15:8]), "R1", "phase step", int'(ph), int'(8'(prev_ph + tw[15:8])));
          end
          first = 0;
          prev_ph = ph;
        end
      end else begin
        check(amp == last_amp && ph == last_ph, "R8", "output hold", int'(amp), int'(last_amp));
      end
      h2 = h1; h1 = en;
    end
    last_amp = amp; last_ph = ph;
  end

  initial begin
    do_reset();
    tw = 16'h0000; drive(1, 50);  drive(0, 4);
    do_reset();
    tw = 16'h0400; drive(1, 300); drive(0, 4);
    do_reset();
    tw = 16'h0100; drive(1, 600); drive(0, 4);
    foreach (q_ph[i]) check(0, "R7", "left over", i, 0);
    do_reset();
    tw = 16'h1234; drive(1, 2000); drive(0, 4);
    do_reset();
    tw = 16'h0101; drive(1, 3000); drive(0, 4);
    do_reset();
    tw = 16'h4E21; drive(1, 2000); drive(0, 4);
    do_reset();
    tw = 16'hB1E0; drive(1, 2000); drive(0, 4);
    do_reset();
    tw = 16'h00FF; drive(1, 3000); drive(0, 4);
    do_reset();
    tw = 16'h0007; drive(1, 5000); drive(0, 4);
    // R8 gapped enable: state must freeze across idle cycles
    do_reset();
    tw = 16'h2A5B;
    for (int i = 0; i < 1500; i++) drive((i % 3) != 0, 1);
    drive(0, 6);
    check(q_ph.size() == 0, "R7", "all samples emitted", q_ph.size(), 0);
    // R9 reset in mid-stream then restart from phase 0
    tw = 16'h3333; drive(1, 40);
    do_reset();
    tw = 16'h0200; drive(1, 200); drive(0, 4);
    check(q_ph.size() == 0, "R7", "queue drained", q_ph.size(), 0);
    finish_up();
  end
endmodule